// File: doc/BRIEF.md
# Scaling Accumulator Datapath

This block is the arithmetic core of a fixed-point signal-processing pipeline. It holds a 32-bit two's-complement accumulator. Each cycle it can combine the accumulator with one 16-bit operand. Before the operand reaches the ALU it is sign-extended to 32 bits and shifted left by 0 to 16 places. The vacated low bits fill with zeros, so the operand can be aligned to any scale of the accumulator. The ALU can load, add or subtract the scaled operand. It can also apply AND, OR or XOR to the low word of the accumulator. It can hold or clear the accumulator.

Two store ports read the result out. The low-word port shows accumulator bits 15..0. The high-word port shows the upper 16 bits after a left scaling of 0, 1 or 4 places. This scaling exists only on the read path; the accumulator itself is never changed by it. A registered overflow flag reports signed wraparound from the last add or subtract.

Top module: `acc_scaler_dp`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and in the cycle after it is released, the accumulator and the overflow flag are zero. So `store_hi`, `store_lo` and `ovf_flag` read 0.
- R2: With `op_sel` = 1 (load), the accumulator takes the operand sign-extended to 32 bits and shifted left by `in_shift` places, with the vacated bits set to zero. A shift count above 16 acts as 16.
- R3: With `op_sel` = 2 (add) or 3 (subtract), the accumulator becomes the accumulator plus or minus the shifted operand of R2, modulo 2^32.
- R4: After an add or subtract, `ovf_flag` is 1 exactly when the operation overflowed in signed arithmetic. An add overflows when both inputs have equal signs and the result's sign differs from them. A subtract overflows when the input signs differ and the result's sign differs from the accumulator's. After a load, a Boolean operation or a clear, the flag is 0.
- R5: With `op_sel` = 4, 5 or 6, the low word of the accumulator becomes its AND, OR or XOR with the unshifted operand. The high word stays unchanged and `in_shift` has no effect.
- R6: With `op_sel` = 0, the accumulator and the flag hold. With `op_sel` = 7, both are cleared.
- R7: `store_lo` is accumulator bits 15..0. `store_hi` is bits 31..16 of the accumulator shifted left by 0, 1 or 4 places for `out_shift` = 0, 1 or 2. The output shift does not modify the accumulator.
- R8: `out_shift` = 3 is treated as a shift of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation: 0 hold, 1 load, 2 add, 3 subtract, 4 AND, 5 OR, 6 XOR, 7 clear |
| opnd_in | input | 16 | Data operand |
| in_shift | input | 5 | Left shift count for the operand, 0..16, larger values clamp to 16 |
| out_shift | input | 2 | Store scaling: 0 none, 1 one place, 2 four places, 3 none |
| store_hi | output | 16 | Scaled high word of the accumulator |
| store_lo | output | 16 | Low word of the accumulator |
| ovf_flag | output | 1 | Signed overflow from the last arithmetic operation |

## Verification
The hardest case to reach from the ports is signed overflow in each direction. This needs the accumulator to sit near the edge of the 32-bit range, which a single 16-bit operand cannot set up. The stimulus first loads a value with a shift of 16, placing the 16-bit value in the top half of the accumulator. Then an add of a second operand shifted by 16 overflows in the positive direction. A subtract of 1 from the most negative value overflows in the negative direction. The vector table keeps accumulator state from one entry to the next. This lets the Boolean operations, the output scaling and the shift clamp all act on known non-trivial contents.

// File: rtl/acc_pkg.sv
package acc_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LOAD = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_XOR  = 3'd6,
      OP_CLR  = 3'd7
   } acc_op_e;
endpackage

// File: rtl/acc_in_shifter.sv
module acc_in_shifter #(
   parameter int DW     = 16,
   parameter int SHW    = 5,
   parameter bit BARREL = 1'b1
) (
   input  logic [DW-1:0]   din,
   input  logic [SHW-1:0]  shamt,
   output logic [2*DW-1:0] dout
);
   localparam int AW = 2 * DW;

   if (SHW < $clog2(DW + 1)) begin : g_bad_shw
      $error("acc_in_shifter: shift count too narrow");
   end

   logic [SHW-1:0] cnt;
   logic [AW-1:0]  ext;

   always_comb cnt = (shamt > SHW'(DW)) ? SHW'(DW) : shamt;
   assign ext = {{DW{din[DW-1]}}, din};

   if (BARREL) begin : g_log
      logic [AW-1:0] stg [SHW+1];
      assign stg[0] = ext;
      for (genvar i = 0; i < SHW; i++) begin : g_stage
         if ((2 ** i) < AW) begin : g_live
            assign stg[i+1] = cnt[i] ? (stg[i] << (2 ** i)) : stg[i];
         end else begin : g_pass
            assign stg[i+1] = stg[i];
         end
      end
      assign dout = stg[SHW];
   end else begin : g_flat
      assign dout = ext << cnt;
   end

   always_comb begin
      // R2
      low_fill_chk: assert ((dout & ((AW'(1) << cnt) - AW'(1))) == '0)
         else $error("shifted operand has nonzero fill bits");
      // R2
      sign_keep_chk: assert (dout[AW-1] == din[DW-1])
         else $error("shifted operand lost its sign");
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DW = 16
) (
   input  acc_op_e         op,
   input  logic [2*DW-1:0] acc,
   input  logic [2*DW-1:0] opnd,
   input  logic [DW-1:0]   raw,
   output logic [2*DW-1:0] res,
   output logic            ovf,
   output logic            upd
);
   localparam int AW = 2 * DW;

   logic [AW-1:0] sum;
   logic [AW-1:0] dif;
   logic          add_ov;
   logic          sub_ov;

   assign sum    = acc + opnd;
   assign dif    = acc - opnd;
   assign add_ov = (acc[AW-1] == opnd[AW-1]) && (sum[AW-1] != acc[AW-1]);
   assign sub_ov = (acc[AW-1] != opnd[AW-1]) && (dif[AW-1] != acc[AW-1]);

   always_comb begin
      res = acc;
      ovf = 1'b0;
      upd = 1'b1;
      unique case (op)
         OP_NOP:  upd = 1'b0;
         OP_LOAD: res = opnd;
         OP_ADD:  begin res = sum; ovf = add_ov; end
         OP_SUB:  begin res = dif; ovf = sub_ov; end
         OP_AND:  res = {acc[AW-1:DW], acc[DW-1:0] & raw};
         OP_OR:   res = {acc[AW-1:DW], acc[DW-1:0] | raw};
         OP_XOR:  res = {acc[AW-1:DW], acc[DW-1:0] ^ raw};
         OP_CLR:  res = '0;
         default: upd = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_out_shifter.sv
module acc_out_shifter #(
   parameter int DW   = 16,
   parameter int SH_A = 1,
   parameter int SH_B = 4
) (
   input  logic [2*DW-1:0] acc,
   input  logic [1:0]      sel,
   output logic [DW-1:0]   hi
);
   localparam int AW = 2 * DW;

   if (SH_A >= DW || SH_B >= DW) begin : g_bad_sh
      $error("acc_out_shifter: store shift must be below word width");
   end

   logic [AW-1:0] scaled;

   always_comb begin
      unique case (sel)
         2'd1:    scaled = acc << SH_A;
         2'd2:    scaled = acc << SH_B;
         default: scaled = acc;
      endcase
   end

   assign hi = scaled[AW-1:DW];

   always_comb begin
      // R8
      osel_illegal_chk: assert (!(sel == 2'd3) || (hi == acc[AW-1:DW]))
         else $error("illegal store shift code not treated as zero");
   end
endmodule

// File: rtl/acc_scaler_dp.sv
module acc_scaler_dp
   import acc_pkg::*;
#(
   parameter  int DW     = 16,
   parameter  bit BARREL = 1'b1,
   parameter  int SH_A   = 1,
   parameter  int SH_B   = 4,
   localparam int SHW    = $clog2(DW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     op_sel,
   input  logic [DW-1:0]  opnd_in,
   input  logic [SHW-1:0] in_shift,
   input  logic [1:0]     out_shift,
   output logic [DW-1:0]  store_hi,
   output logic [DW-1:0]  store_lo,
   output logic           ovf_flag
);
   localparam int AW = 2 * DW;

   if (DW < 8) begin : g_bad_dw
      $error("acc_scaler_dp: word width too small");
   end

   logic [AW-1:0] acc_q;
   logic          ovf_q;
   logic [AW-1:0] opnd_sh;
   logic [AW-1:0] acc_n;
   logic          ovf_n;
   logic          upd;

   acc_in_shifter #(.DW(DW), .SHW(SHW), .BARREL(BARREL)) u_ish (
      .din   (opnd_in),
      .shamt (in_shift),
      .dout  (opnd_sh)
   );

   acc_alu #(.DW(DW)) u_alu (
      .op   (acc_op_e'(op_sel)),
      .acc  (acc_q),
      .opnd (opnd_sh),
      .raw  (opnd_in),
      .res  (acc_n),
      .ovf  (ovf_n),
      .upd  (upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (upd) begin
         acc_q <= acc_n;
         ovf_q <= ovf_n;
      end
   end

   acc_out_shifter #(.DW(DW), .SH_A(SH_A), .SH_B(SH_B)) u_osh (
      .acc (acc_q),
      .sel (out_shift),
      .hi  (store_hi)
   );

   assign store_lo = acc_q[DW-1:0];
   assign ovf_flag = ovf_q;

   // R6
   nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd0) |=> ($stable(acc_q) && $stable(ovf_q)))
      else $error("hold changed accumulator state");

   // R5
   bool_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel inside {3'd4, 3'd5, 3'd6}) |=> (acc_q[AW-1:DW] == $past(acc_q[AW-1:DW])))
      else $error("Boolean operation altered the high word");

   // R4
   add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd2) |=> (ovf_q == (($past(acc_q[AW-1]) == $past(opnd_sh[AW-1]))
                                      && (acc_q[AW-1] != $past(acc_q[AW-1])))))
      else $error("overflow flag wrong after add");
endmodule

// File: tb/tb_acc_scaler_dp.sv
module tb_acc_scaler_dp;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 21;
   localparam int WATCHDOG = 5000;

   // {op, operand, in_shift, out_shift, exp_hi, exp_lo, exp_ovf}
   localparam logic [58:0] VEC [NV] = '{
      {3'd1, 16'h1234, 5'd4,  2'd0, 16'h0001, 16'h2340, 1'b0},
      {3'd1, 16'h8000, 5'd16, 2'd0, 16'h8000, 16'h0000, 1'b0},
      {3'd1, 16'h8001, 5'd0,  2'd0, 16'hFFFF, 16'h8001, 1'b0},
      {3'd2, 16'h0001, 5'd0,  2'd0, 16'hFFFF, 16'h8002, 1'b0},
      {3'd1, 16'h7FFF, 5'd16, 2'd0, 16'h7FFF, 16'h0000, 1'b0},
      {3'd2, 16'h7FFF, 5'd16, 2'd0, 16'hFFFE, 16'h0000, 1'b1},
      {3'd3, 16'h0001, 5'd0,  2'd0, 16'hFFFD, 16'hFFFF, 1'b0},
      {3'd1, 16'h8000, 5'd16, 2'd0, 16'h8000, 16'h0000, 1'b0},
      {3'd3, 16'h0001, 5'd0,  2'd0, 16'h7FFF, 16'hFFFF, 1'b1},
      {3'd0, 16'h0000, 5'd0,  2'd1, 16'hFFFF, 16'hFFFF, 1'b1},
      {3'd1, 16'h1234, 5'd8,  2'd2, 16'h0123, 16'h3400, 1'b0},
      {3'd0, 16'h0000, 5'd0,  2'd3, 16'h0012, 16'h3400, 1'b0},
      {3'd4, 16'h0F0F, 5'd8,  2'd0, 16'h0012, 16'h0400, 1'b0},
      {3'd5, 16'hF000, 5'd3,  2'd0, 16'h0012, 16'hF400, 1'b0},
      {3'd6, 16'hFFFF, 5'd16, 2'd0, 16'h0012, 16'h0BFF, 1'b0},
      {3'd7, 16'h5555, 5'd2,  2'd0, 16'h0000, 16'h0000, 1'b0},
      {3'd1, 16'hFFFF, 5'd31, 2'd0, 16'hFFFF, 16'h0000, 1'b0},
      {3'd1, 16'h0003, 5'd17, 2'd0, 16'h0003, 16'h0000, 1'b0},
      {3'd2, 16'hFFFF, 5'd4,  2'd0, 16'h0002, 16'hFFF0, 1'b0},
      {3'd0, 16'h0000, 5'd0,  2'd1, 16'h0005, 16'hFFF0, 1'b0},
      {3'd0, 16'h0000, 5'd0,  2'd0, 16'h0002, 16'hFFF0, 1'b0}
   };
   localparam string TAG [NV] = '{
      "R2", "R2", "R2", "R3", "R2", "R4", "R3", "R2", "R4", "R7",
      "R7", "R8", "R5", "R5", "R5", "R6", "R2", "R2", "R3", "R7", "R6"
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [15:0] opnd_in = 16'h0;
   logic [4:0]  in_shift = 5'd0;
   logic [1:0]  out_shift = 2'd0;
   logic [15:0] store_hi;
   logic [15:0] store_lo;
   logic        ovf_flag;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_scaler_dp dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_sel    (op_sel),
      .opnd_in   (opnd_in),
      .in_shift  (in_shift),
      .out_shift (out_shift),
      .store_hi  (store_hi),
      .store_lo  (store_lo),
      .ovf_flag  (ovf_flag)
   );

   task automatic check(input string tag, input logic [15:0] eh, input logic [15:0] el,
                        input logic eo);
      n_run++;
      if (store_hi !== eh || store_lo !== el || ovf_flag !== eo) begin
         n_fail++;
         $display("FAIL %s: hi=%h lo=%h ovf=%b expected hi=%h lo=%h ovf=%b",
                  tag, store_hi, store_lo, ovf_flag, eh, el, eo);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs zero during reset
      check("R1", 16'h0, 16'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: still zero the cycle after release
      check("R1", 16'h0, 16'h0, 1'b0);
      for (int i = 0; i < NV; i++) begin
         op_sel    = VEC[i][58:56];
         opnd_in   = VEC[i][55:40];
         in_shift  = VEC[i][39:35];
         out_shift = VEC[i][34:33];
         @(negedge clk);
         check(TAG[i], VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
      end
      // R1: asynchronous reset in mid-run clears a nonzero accumulator
      op_sel = 3'd0;
      out_shift = 2'd0;
      #1 rst_n = 1'b0;
      #1 check("R1", 16'h0, 16'h0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      // R8: illegal store code on a value whose shift would differ
      op_sel = 3'd1; opnd_in = 16'h4321; in_shift = 5'd12; out_shift = 2'd3;
      @(negedge clk);
      check("R8", 16'h0432, 16'h1000, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule